// File: doc/BRIEF.md
# Pseudo-SRAM Configuration Register Unit

This unit holds the configuration word of a burst-capable pseudo-static memory. When the control strobes show a configuration-write cycle, it captures the low address bits into a stored word on the rising clock edge. Chip select, address-valid, write enable and both byte enables must be low, the configuration-select pin must be low, and output enable must be high. The stored word is decoded into configuration outputs: drive strength, operating mode, wait polarity, first-data latency, burst ordering, burst length and partial-refresh setup. The memory core, the refresh engine and the I/O pads use these outputs.

Each field is decoded on its own. A reserved code sends only that field to its default. A set reserved bit 12 raises a sticky warning. Address bits 21:18 are never stored.

The unit also watches mode changes against the memory's write history. It raises a one-cycle pulse when a load drops synchronous burst writes in favour of asynchronous writes. It raises another one-cycle pulse when a synchronous mode is entered while an asynchronous write is still waiting for its flushing dummy write.

Top module: `psram_mode_reg`

## Requirements
- R1: The word loads on a rising edge only if ce_n, adv_n, we_n, ub_n, lb_n and cfg_sel_n are all 0 and oe_n is 1. The outputs change in the cycle after that edge. Any other strobe combination leaves every output unchanged.
- R2: After reset the outputs hold the defaults. These are drive 00 (full), mode 00, wait active-low, latency 4, linear burst, length 8, partial refresh disabled, bottom array, size code 00, and all flags low.
- R3: drive_o follows bits 17:16, where 00 is full, 01 is half and 10 is quarter; code 11 gives 00. mode_o follows bits 15:14, where 00 is async page read with async write, 01 is sync burst read with async write and 10 is sync burst read with sync burst write; code 11 gives 00.
- R4: lat_o follows bits 11:9, with codes 000, 001, 010 and 011 giving 3, 4, 5 and 6 clocks. Any code with bit 11 set gives 4.
- R5: burst_len_o follows bits 7:5, with 010 giving 4, 011 giving 8, 100 giving 16 and 111 giving 256 words; codes 000, 001, 101 and 110 give 8. burst_ilv_o is bit 8, where 1 means interleaved.
- R6: wait_hi_o is bit 13. par_en_o is 1 only for bits 4:3 = 10; code 11 and the reserved codes 00 and 01 give 0. par_top_o is bit 2, and par_size_o is bits 1:0 (00 full, 01 3/4, 10 1/2, 11 1/4).
- R7: A reserved code in one field leaves every other field at its decoded value. Bits 21:18 have no effect.
- R8: A load with bit 12 set sets cfg_warn_o until reset, and the other fields decode as usual.
- R9: wr_mode_viol_o pulses for exactly one cycle after a load that moves the effective mode from 10 to 00 or 01. Reserved code 11 counts as 00.
- R10: A non-dummy write (wr_done_i=1, wr_dummy_i=0) in mode 00 or 01 marks a pending async write, and a dummy write clears it. sync_entry_viol_o pulses for one cycle after a load made while a write is pending that changes the effective mode to 01 or 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Address valid, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| ub_n | input | 1 | Upper byte enable, active low |
| lb_n | input | 1 | Lower byte enable, active low |
| cfg_sel_n | input | 1 | Configuration-register select, active low |
| addr | input | 22 | Address bus, carries the configuration word |
| wr_done_i | input | 1 | An array write completed this cycle |
| wr_dummy_i | input | 1 | The completed write is a dummy (flushing) write |
| drive_o | output | 2 | Drive strength code |
| mode_o | output | 2 | Effective operating mode |
| wait_hi_o | output | 1 | Wait signal active high |
| lat_o | output | 3 | First-data latency in clocks |
| burst_ilv_o | output | 1 | Interleaved burst ordering |
| burst_len_o | output | 9 | Burst length in words |
| par_en_o | output | 1 | Partial refresh enabled |
| par_top_o | output | 1 | Partial refresh keeps the top array |
| par_size_o | output | 2 | Partial refresh size code |
| wr_mode_viol_o | output | 1 | Forbidden sync-write to async-write change |
| sync_entry_viol_o | output | 1 | Sync mode entered without a dummy write |
| cfg_warn_o | output | 1 | Sticky: reserved bit 12 was written |

## Verification
Almost-valid loads are the main target: each has one strobe wrong, or output enable low. A design that decoded too few strobes would change its configuration on these. Words with every field reserved at once, and words with only one field reserved, catch a fallback that resets the whole word or picks the wrong default. They also catch high address bits leaking into the decode. The transition sequences go from sync-write to async, including through the reserved mode code. They enter sync mode with and without a flushing dummy write, and check the cycle after each pulse. A flag that stayed high, missed the reserved-code case, or ignored the dummy write would show up there.

// File: rtl/psram_cfg_pkg.sv
package psram_cfg_pkg;
  localparam int ADDR_W = 22;
  localparam int CFG_W  = 18;
  localparam int FULL_PAGE = 256;
  localparam int BL_W   = $clog2(FULL_PAGE) + 1;

  typedef enum logic [1:0] {
    MODE_ASYNC   = 2'b00,
    MODE_SRD_AWR = 2'b01,
    MODE_SYNC    = 2'b10
  } op_mode_e;

  typedef struct packed {
    logic [1:0]      drive;
    op_mode_e        mode;
    logic            wait_hi;
    logic [2:0]      lat;
    logic            ilv;
    logic [BL_W-1:0] blen;
    logic            par_en;
    logic            par_top;
    logic [1:0]      par_size;
  } cfg_t;

  // Stored word after reset: every field at its default code
  localparam logic [CFG_W-1:0] CFG_RESET =
    {2'b00, 2'b00, 1'b0, 1'b0, 3'b001, 1'b0, 3'b011, 2'b11, 1'b0, 2'b00};
endpackage

// File: rtl/cfg_word_reg.sv
module cfg_word_reg
  import psram_cfg_pkg::*;
#(
  parameter int W = CFG_W,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (load_en) word_d = word_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= RST_VAL;
    else        word_q <= word_d;
  end

  assign word_o = word_q;

  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(word_q)); // R1
endmodule

// File: rtl/cfg_field_decode.sv
module cfg_field_decode
  import psram_cfg_pkg::*;
(
  input  logic [CFG_W-1:0] word_i,
  output cfg_t             cfg_o
);
  logic unused_rsvd_bit;
  assign unused_rsvd_bit = word_i[12];

  always_comb begin
    cfg_o = '0;
    // drive strength: code 11 reserved
    cfg_o.drive = (word_i[17:16] == 2'b11) ? 2'b00 : word_i[17:16];
    // operating mode: code 11 reserved
    case (word_i[15:14])
      2'b01:   cfg_o.mode = MODE_SRD_AWR;
      2'b10:   cfg_o.mode = MODE_SYNC;
      default: cfg_o.mode = MODE_ASYNC;
    endcase
    cfg_o.wait_hi = word_i[13];
    // latency: bit 11 set means reserved
    cfg_o.lat = word_i[11] ? 3'd4 : (3'd3 + {1'b0, word_i[10:9]});
    cfg_o.ilv = word_i[8];
    case (word_i[7:5])
      3'b010:  cfg_o.blen = BL_W'(4);
      3'b011:  cfg_o.blen = BL_W'(8);
      3'b100:  cfg_o.blen = BL_W'(16);
      3'b111:  cfg_o.blen = BL_W'(FULL_PAGE);
      default: cfg_o.blen = BL_W'(8);
    endcase
    // partial refresh: only 10 enables, everything else disables
    cfg_o.par_en   = (word_i[4:3] == 2'b10);
    cfg_o.par_top  = word_i[2];
    cfg_o.par_size = word_i[1:0];
  end
endmodule

// File: rtl/mode_xition_check.sv
module mode_xition_check
  import psram_cfg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_en,
  input  op_mode_e cur_mode,
  input  op_mode_e new_mode,
  input  logic     wr_done,
  input  logic     wr_dummy,
  output logic     wr_viol_o,
  output logic     sync_viol_o
);
  logic pend_q, pend_d;
  logic wr_viol_q, wr_viol_d;
  logic sync_viol_q, sync_viol_d;
  logic cur_async_wr;

  assign cur_async_wr = (cur_mode != MODE_SYNC);

  always_comb begin
    wr_viol_d   = load_en && (cur_mode == MODE_SYNC) && (new_mode != MODE_SYNC);
    sync_viol_d = load_en && pend_q && (new_mode != MODE_ASYNC) &&
                  (new_mode != cur_mode);
    pend_d = pend_q;
    if (wr_done) begin
      if (wr_dummy)          pend_d = 1'b0;
      else if (cur_async_wr) pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      wr_viol_q   <= 1'b0;
      sync_viol_q <= 1'b0;
    end else begin
      pend_q      <= pend_d;
      wr_viol_q   <= wr_viol_d;
      sync_viol_q <= sync_viol_d;
    end
  end

  assign wr_viol_o   = wr_viol_q;
  assign sync_viol_o = sync_viol_q;

  AST_WR_VIOL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_viol_q |=> !wr_viol_q); // R9
  AST_WR_VIOL_LANDS_ASYNC: assert property (@(posedge clk) disable iff (!rst_n)
    wr_viol_q |-> (cur_mode != MODE_SYNC)); // R9
  AST_SYNC_VIOL_LANDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    sync_viol_q |-> (cur_mode != MODE_ASYNC)); // R10
  AST_DUMMY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && wr_dummy && !load_en) |=> !sync_viol_q); // R10
endmodule

// File: rtl/psram_mode_reg.sv
module psram_mode_reg
  import psram_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              adv_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic              cfg_sel_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_done_i,
  input  logic              wr_dummy_i,
  output logic [1:0]        drive_o,
  output logic [1:0]        mode_o,
  output logic              wait_hi_o,
  output logic [2:0]        lat_o,
  output logic              burst_ilv_o,
  output logic [BL_W-1:0]   burst_len_o,
  output logic              par_en_o,
  output logic              par_top_o,
  output logic [1:0]        par_size_o,
  output logic              wr_mode_viol_o,
  output logic              sync_entry_viol_o,
  output logic              cfg_warn_o
);
  logic             load_en;
  logic [CFG_W-1:0] word_q;
  cfg_t             cur_cfg, new_cfg;
  logic             warn_q, warn_d;
  logic             unused_hi_bits;

  // Configuration-write cycle decode
  assign load_en = !ce_n && !adv_n && !we_n && !ub_n && !lb_n && !cfg_sel_n && oe_n;
  assign unused_hi_bits = ^addr[ADDR_W-1:CFG_W];

  cfg_word_reg #(.W(CFG_W), .RST_VAL(CFG_RESET)) u_word (
    .clk(clk), .rst_n(rst_n), .load_en(load_en),
    .word_i(addr[CFG_W-1:0]), .word_o(word_q));

  cfg_field_decode u_dec_cur (.word_i(word_q),           .cfg_o(cur_cfg));
  cfg_field_decode u_dec_new (.word_i(addr[CFG_W-1:0]),  .cfg_o(new_cfg));

  mode_xition_check u_xchk (
    .clk(clk), .rst_n(rst_n), .load_en(load_en),
    .cur_mode(cur_cfg.mode), .new_mode(new_cfg.mode),
    .wr_done(wr_done_i), .wr_dummy(wr_dummy_i),
    .wr_viol_o(wr_mode_viol_o), .sync_viol_o(sync_entry_viol_o));

  always_comb begin
    warn_d = warn_q;
    if (load_en && addr[12]) warn_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warn_q <= 1'b0;
    else        warn_q <= warn_d;
  end

  assign drive_o     = cur_cfg.drive;
  assign mode_o      = cur_cfg.mode;
  assign wait_hi_o   = cur_cfg.wait_hi;
  assign lat_o       = cur_cfg.lat;
  assign burst_ilv_o = cur_cfg.ilv;
  assign burst_len_o = cur_cfg.blen;
  assign par_en_o    = cur_cfg.par_en;
  assign par_top_o   = cur_cfg.par_top;
  assign par_size_o  = cur_cfg.par_size;
  assign cfg_warn_o  = warn_q;

  AST_WARN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_warn_o |=> cfg_warn_o); // R8
  AST_LAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_o >= 3'd3) && (lat_o <= 3'd6)); // R4
  AST_BLEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(burst_len_o) && (burst_len_o >= BL_W'(4))); // R5
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'b11); // R3
  AST_DRIVE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    drive_o != 2'b11); // R3
endmodule

// File: tb/psram_mode_reg_tb.sv
module psram_mode_reg_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1, adv_n = 1, we_n = 1, oe_n = 1, ub_n = 1, lb_n = 1, cfg_sel_n = 1;
  logic [21:0] addr = '0;
  logic wr_done_i = 0, wr_dummy_i = 0;
  logic [1:0] drive_o, mode_o, par_size_o;
  logic wait_hi_o, burst_ilv_o, par_en_o, par_top_o;
  logic [2:0] lat_o;
  logic [8:0] burst_len_o;
  logic wr_mode_viol_o, sync_entry_viol_o, cfg_warn_o;

  always #4 clk = ~clk;

  psram_mode_reg dut_i (.*);

  typedef struct { logic [24:0] v; string tag; } exp_t;
  exp_t sb_q[$];
  int n_chk = 0, n_err = 0;
  bit done = 0;

  // bench model state
  logic [21:0] cur_f;
  logic [1:0]  cur_md = 0;
  bit pend = 0, warn = 0;

  function automatic logic [21:0] model(input logic [21:0] a);
    logic [1:0] drv, md; logic [2:0] lat; logic [8:0] bl;
    drv = (a[17:16] == 2'b11) ? 2'b00 : a[17:16];
    md  = (a[15:14] == 2'b11) ? 2'b00 : a[15:14];
    lat = a[11] ? 3'd4 : 3'd3 + {1'b0, a[10:9]};
    case (a[7:5]) 3'b010: bl = 4; 3'b011: bl = 8; 3'b100: bl = 16; 3'b111: bl = 256;
      default: bl = 8; endcase
    return {drv, md, a[13], lat, a[8], bl, (a[4:3] == 2'b10), a[2], a[1:0]};
  endfunction

  task automatic push(input bit wv, input bit sv, input string tag);
    exp_t e; e.v = {cur_f, wv, sv, warn}; e.tag = tag; sb_q.push_back(e);
  endtask

  task automatic mrs(input logic [21:0] a, input int bad, input string tag);
    logic [1:0] nm; bit wv, sv;
    @(negedge clk);
    ce_n = 0; adv_n = 0; we_n = 0; ub_n = 0; lb_n = 0; cfg_sel_n = 0; oe_n = 1; addr = a;
    if (bad == 1) ub_n = 1;
    if (bad == 2) oe_n = 0;
    if (bad == 3) cfg_sel_n = 1;
    @(posedge clk); #1;
    ce_n = 1; adv_n = 1; we_n = 1; ub_n = 1; lb_n = 1; cfg_sel_n = 1; oe_n = 1;
    wv = 0; sv = 0;
    if (bad == 0) begin
      nm = model(a)[19:18];
      wv = (cur_md == 2'b10) && (nm != 2'b10);
      sv = pend && (nm != 2'b00) && (nm != cur_md);
      warn = warn | a[12];
      cur_f = model(a); cur_md = nm;
    end
    push(wv, sv, tag);
  endtask

  task automatic idle(input string tag);
    @(posedge clk); #1; push(0, 0, tag);
  endtask

  task automatic wr(input bit dummy);
    @(negedge clk); wr_done_i = 1; wr_dummy_i = dummy;
    @(posedge clk); #1; wr_done_i = 0; wr_dummy_i = 0;
    if (dummy) pend = 0; else if (cur_md != 2'b10) pend = 1;
  endtask

  // monitor: compare queued expectations away from the active edge
  initial forever begin
    @(negedge clk);
    while (sb_q.size() > 0) begin
      exp_t e; logic [24:0] act;
      e = sb_q.pop_front();
      act = {drive_o, mode_o, wait_hi_o, lat_o, burst_ilv_o, burst_len_o,
             par_en_o, par_top_o, par_size_o, wr_mode_viol_o, sync_entry_viol_o, cfg_warn_o};
      n_chk++;
      if (act !== e.v) begin
        n_err++;
        $display("FAIL %s: actual=%h expected=%h", e.tag, act, e.v);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    cur_f = model(22'h0_0_2_0_6_3 | 22'h0);
    cur_f = {2'b00, 2'b00, 1'b0, 3'd4, 1'b0, 9'd8, 1'b0, 1'b0, 2'b00};
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle("R2 reset defaults");
    // R3 R4 R5 R6 all-valid word
    mrs({4'h0, 2'b10, 2'b00, 1'b1, 1'b0, 3'b011, 1'b1, 3'b111, 2'b10, 1'b1, 2'b11}, 0, "R3 R4 R5 R6 valid word A");
    mrs({4'h0, 2'b01, 2'b00, 1'b0, 1'b0, 3'b010, 1'b0, 3'b100, 2'b10, 1'b0, 2'b10}, 0, "R4 R5 valid word B");
    mrs({4'h0, 2'b00, 2'b01, 1'b0, 1'b0, 3'b000, 1'b0, 3'b010, 2'b11, 1'b0, 2'b01}, 0, "R3 R4 R5 valid word C");
    // R1 near-miss strobes
    mrs(22'h3FFFFF, 1, "R1 ub_n high ignored");
    mrs(22'h3FFFFF, 2, "R1 oe_n low ignored");
    mrs(22'h3FFFFF, 3, "R1 cfg_sel_n high ignored");
    // R7 every field reserved, high bits set
    mrs({4'hF, 2'b11, 2'b11, 1'b1, 1'b0, 3'b111, 1'b1, 3'b000, 2'b01, 1'b1, 2'b10}, 0, "R7 all reserved");
    // R7 only burst length reserved
    mrs({4'h5, 2'b01, 2'b00, 1'b1, 1'b0, 3'b010, 1'b0, 3'b101, 2'b10, 1'b0, 2'b11}, 0, "R5 R7 length 101 only");
    mrs({4'h0, 2'b10, 2'b00, 1'b0, 1'b0, 3'b100, 1'b1, 3'b110, 2'b00, 1'b1, 2'b00}, 0, "R4 R6 R7 lat/par reserved");
    // R8 reserved bit 12
    mrs({4'h0, 2'b01, 2'b00, 1'b1, 1'b1, 3'b001, 1'b0, 3'b011, 2'b10, 1'b0, 2'b01}, 0, "R8 bit12 warn");
    mrs({4'h0, 2'b00, 2'b00, 1'b0, 1'b0, 3'b001, 1'b0, 3'b011, 2'b11, 1'b0, 2'b00}, 0, "R8 warn sticky");
    // R9 sync write -> async
    mrs({4'h0, 2'b00, 2'b10, 1'b0, 1'b0, 3'b001, 1'b0, 3'b011, 2'b11, 1'b0, 2'b00}, 0, "R9 enter sync write");
    mrs({4'h0, 2'b00, 2'b01, 1'b0, 1'b0, 3'b001, 1'b0, 3'b011, 2'b11, 1'b0, 2'b00}, 0, "R9 sync->01 pulse");
    idle("R9 pulse one cycle");
    mrs({4'h0, 2'b00, 2'b10, 1'b0, 1'b0, 3'b001, 1'b0, 3'b011, 2'b11, 1'b0, 2'b00}, 0, "R9 sync again");
    mrs({4'h0, 2'b00, 2'b11, 1'b0, 1'b0, 3'b001, 1'b0, 3'b011, 2'b11, 1'b0, 2'b00}, 0, "R9 sync->reserved pulse");
    mrs({4'h0, 2'b00, 2'b10, 1'b0, 1'b0, 3'b001, 1'b0, 3'b011, 2'b11, 1'b0, 2'b00}, 0, "R9 R10 from 00 to sync no pending");
    mrs({4'h0, 2'b00, 2'b10, 1'b0, 1'b0, 3'b001, 1'b0, 3'b011, 2'b11, 1'b0, 2'b00}, 0, "R9 same sync no pulse");
    mrs(22'h0, 0, "R9 back to 00 pulse");
    // R10 pending async write
    wr(0);
    mrs({4'h0, 2'b00, 2'b01, 1'b0, 1'b0, 3'b001, 1'b0, 3'b011, 2'b11, 1'b0, 2'b00}, 0, "R10 sync entry without dummy");
    idle("R10 pulse one cycle");
    mrs(22'h0, 0, "R10 back to 00");
    wr(0); wr(1);
    mrs({4'h0, 2'b00, 2'b10, 1'b0, 1'b0, 3'b001, 1'b0, 3'b011, 2'b11, 1'b0, 2'b00}, 0, "R10 dummy write clears");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule